// File: doc/BRIEF.md
# Hardware Lock Bank for Multi-Core Mutual Exclusion

This block is a bank of hardware lock words that several cores share through a simple register interface. Each lock is one byte of state. A value of zero means the lock is free. A nonzero value is the identifier of the core that holds it. Core identifiers are built outside the block and are never zero.

A core takes a lock by writing its own identifier to the lock word. It then reads the word back to see whether it won. It releases the lock by writing the same identifier again. The same write therefore claims a free lock, frees a lock the writer holds, and does nothing to a lock that another core holds. A core that loses reads back a foreign identifier and retries later.

The bank has several requester ports, one per bus master. Each port gets a read response one cycle after its request. When more than one port writes the same lock in a cycle, the lowest-numbered port decides the outcome.

Top module: `hwlock_bank`

## Requirements
- R1: After reset every lock reads as 0 (free).
- R2: A write of a nonzero identifier to a lock whose value is 0 stores that identifier.
- R3: A write whose identifier equals the stored value sets the lock back to 0.
- R4: A write of a nonzero identifier that differs from a nonzero stored value leaves the lock unchanged.
- R5: A write with data 0 never changes any lock.
- R6: A word index at or above NUM_LOCKS is out of range. A write to an out-of-range index changes no lock, and a read of it returns 0.
- R7: Lock n sits at byte address 4·n. The word index is address bits [ADDR_W-1:2], and address bits [1:0] are ignored.
- R8: When several ports write the same lock in one cycle, only the lowest-numbered writing port is applied, using rules R2 to R4. The writes from the other ports in that cycle are dropped.
- R9: A read request (valid=1, write=0) produces rsp_valid=1 on the next cycle, with the lock value that includes every write from earlier cycles but no write from the request's own cycle.
- R10: Writes from different ports to different locks in the same cycle all take effect.
- R11: In any cycle where rsp_valid is 0 for a port, that port's rsp_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | NUM_PORTS | Per-port request strobe |
| req_write | input | NUM_PORTS | Per-port direction: 1 means write, 0 means read |
| req_addr | input | NUM_PORTS*ADDR_W | Per-port byte address; port p uses bits [p*ADDR_W +: ADDR_W] |
| req_wdata | input | NUM_PORTS*8 | Per-port identifier to write |
| rsp_valid | output | NUM_PORTS | Per-port read response strobe, one cycle after the read |
| rsp_rdata | output | NUM_PORTS*8 | Per-port read data; 0 when there is no response |

## Verification
The assertions assume that all request inputs are known from reset release onward. They also assume that NUM_LOCKS is below 2^(ADDR_W-2), so that out-of-range indexes can be expressed at all. The lock-value properties further assume that a dropped losing write does not count as a write of its own.

The stimulus drives and clears every request on the falling clock edge. It keeps each request to a single cycle and only uses addresses that fit in ADDR_W bits. Same-cycle collisions are produced only on purpose, by driving both ports at the same edge.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;
  localparam int OWNER_W = 8;
  typedef logic [OWNER_W-1:0] owner_t;
  localparam owner_t OWNER_FREE = '0;
endpackage

// File: rtl/hwlock_decode.sv
module hwlock_decode #(
  parameter int ADDR_W    = 8,
  parameter int NUM_LOCKS = 6,
  parameter int IDX_W     = 3
) (
  input  logic                        valid_i,
  input  logic                        write_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  hwlock_pkg::owner_t          wdata_i,
  output logic                        rd_req_o,
  output logic                        wr_req_o,
  output logic                        in_range_o,
  output logic [IDX_W-1:0]            idx_o
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] LIMIT = WIDX_W'(NUM_LOCKS);

  logic [WIDX_W-1:0] word_idx;

  always_comb begin
    word_idx   = addr_i[ADDR_W-1:2];
    in_range_o = (word_idx < LIMIT);
    idx_o      = word_idx[IDX_W-1:0];
    rd_req_o   = valid_i && !write_i;
    wr_req_o   = valid_i && write_i && in_range_o && (wdata_i != hwlock_pkg::OWNER_FREE);
  end
endmodule

// File: rtl/hwlock_prio.sv
module hwlock_prio #(
  parameter int N = 2
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  logic found;

  always_comb begin
    grant_o = '0;
    found   = 1'b0;
    for (int p = 0; p < N; p++) begin
      if (req_i[p] && !found) begin
        grant_o[p] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hwlock_cell.sv
module hwlock_cell #(
  parameter int NUM_PORTS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        hit_i,
  input  logic [NUM_PORTS*8-1:0]      id_i,
  output hwlock_pkg::owner_t          lock_o
);
  import hwlock_pkg::*;

  logic [NUM_PORTS-1:0] grant;
  owner_t               win_id;
  owner_t               lock_q;
  owner_t               lock_d;
  logic                 upd;

  hwlock_prio #(.N(NUM_PORTS)) u_prio (
    .req_i   (hit_i),
    .grant_o (grant)
  );

  always_comb begin
    win_id = OWNER_FREE;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (grant[p]) win_id = win_id | id_i[p*OWNER_W +: OWNER_W];
    end
    upd = |grant;
    if (lock_q == OWNER_FREE)  lock_d = win_id;
    else if (win_id == lock_q) lock_d = OWNER_FREE;
    else                       lock_d = lock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lock_q <= OWNER_FREE;
    else if (upd) lock_q <= lock_d;
  end

  assign lock_o = lock_q;

  p_claim_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && lock_q == OWNER_FREE) |=> lock_q == $past(win_id));
  p_owner_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && lock_q != OWNER_FREE && win_id == lock_q) |=> lock_q == OWNER_FREE);
  p_foreign_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && lock_q != OWNER_FREE && win_id != lock_q) |=> $stable(lock_q));
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(lock_q));
  p_win_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> win_id != OWNER_FREE);
  p_single_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_grant_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i[0] |-> grant[0]);
endmodule

// File: rtl/hwlock_rdport.sv
module hwlock_rdport #(
  parameter int NUM_LOCKS = 6,
  parameter int IDX_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_req_i,
  input  logic                        in_range_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [NUM_LOCKS*8-1:0]      lock_flat_i,
  output logic                        rsp_valid_o,
  output hwlock_pkg::owner_t          rsp_rdata_o
);
  import hwlock_pkg::*;

  owner_t sel;
  owner_t data_d;
  logic   valid_d;

  always_comb begin
    sel = OWNER_FREE;
    for (int l = 0; l < NUM_LOCKS; l++) begin
      if (idx_i == IDX_W'(l)) sel = lock_flat_i[l*OWNER_W +: OWNER_W];
    end
    valid_d = rd_req_i;
    data_d  = (rd_req_i && in_range_i) ? sel : OWNER_FREE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= OWNER_FREE;
    end else begin
      rsp_valid_o <= valid_d;
      rsp_rdata_o <= data_d;
    end
  end

  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |=> rsp_valid_o);
  p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |=> !rsp_valid_o);
  p_oob_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && !in_range_i) |=> rsp_rdata_o == OWNER_FREE);
  p_quiet_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid_o |-> rsp_rdata_o == OWNER_FREE);
endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank #(
  parameter int NUM_PORTS = 2,
  parameter int NUM_LOCKS = 6,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        req_valid,
  input  logic [NUM_PORTS-1:0]        req_write,
  input  logic [NUM_PORTS*ADDR_W-1:0] req_addr,
  input  logic [NUM_PORTS*8-1:0]      req_wdata,
  output logic [NUM_PORTS-1:0]        rsp_valid,
  output logic [NUM_PORTS*8-1:0]      rsp_rdata
);
  import hwlock_pkg::*;

  localparam int IDX_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1;

  logic [NUM_PORTS-1:0]       rd_req;
  logic [NUM_PORTS-1:0]       wr_req;
  logic [NUM_PORTS-1:0]       in_range;
  logic [NUM_PORTS*IDX_W-1:0] idx_flat;
  logic [NUM_LOCKS*8-1:0]     lock_flat;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    hwlock_decode #(.ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) u_dec (
      .valid_i    (req_valid[p]),
      .write_i    (req_write[p]),
      .addr_i     (req_addr[p*ADDR_W +: ADDR_W]),
      .wdata_i    (req_wdata[p*OWNER_W +: OWNER_W]),
      .rd_req_o   (rd_req[p]),
      .wr_req_o   (wr_req[p]),
      .in_range_o (in_range[p]),
      .idx_o      (idx_flat[p*IDX_W +: IDX_W])
    );

    hwlock_rdport #(.NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_req_i    (rd_req[p]),
      .in_range_i  (in_range[p]),
      .idx_i       (idx_flat[p*IDX_W +: IDX_W]),
      .lock_flat_i (lock_flat),
      .rsp_valid_o (rsp_valid[p]),
      .rsp_rdata_o (rsp_rdata[p*OWNER_W +: OWNER_W])
    );
  end

  for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lock
    logic [NUM_PORTS-1:0] hit;

    always_comb begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        hit[p] = wr_req[p] && (idx_flat[p*IDX_W +: IDX_W] == IDX_W'(l));
      end
    end

    hwlock_cell #(.NUM_PORTS(NUM_PORTS)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (hit),
      .id_i   (req_wdata),
      .lock_o (lock_flat[l*OWNER_W +: OWNER_W])
    );
  end
endmodule

// File: tb/hwlock_bank_tb.sv
`timescale 1ns/1ps
module hwlock_bank_tb;
  localparam int NP = 2;
  localparam int NL = 6;
  localparam int AW = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NP-1:0]    req_valid;
  logic [NP-1:0]    req_write;
  logic [NP*AW-1:0] req_addr;
  logic [NP*8-1:0]  req_wdata;
  logic [NP-1:0]    rsp_valid;
  logic [NP*8-1:0]  rsp_rdata;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  hwlock_bank #(.NUM_PORTS(NP), .NUM_LOCKS(NL), .ADDR_W(AW)) u_dut (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata, .rsp_valid, .rsp_rdata
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_port(int p, logic v, logic w, logic [AW-1:0] a, logic [7:0] d);
    req_valid[p]          = v;
    req_write[p]          = w;
    req_addr[p*AW +: AW]  = a;
    req_wdata[p*8 +: 8]   = d;
  endtask

  task automatic idle_all();
    for (int p = 0; p < NP; p++) set_port(p, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic wr(int p, logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    set_port(p, 1'b1, 1'b1, a, d);
    @(negedge clk);
    idle_all();
  endtask

  task automatic wr2(logic [AW-1:0] a0, logic [7:0] d0, logic [AW-1:0] a1, logic [7:0] d1);
    @(negedge clk);
    set_port(0, 1'b1, 1'b1, a0, d0);
    set_port(1, 1'b1, 1'b1, a1, d1);
    @(negedge clk);
    idle_all();
  endtask

  task automatic rd(int p, logic [AW-1:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    set_port(p, 1'b1, 1'b0, a, '0);
    @(negedge clk);
    chk({tag, " rsp_valid"}, {7'b0, rsp_valid[p]}, 8'h01);
    chk(tag, rsp_rdata[p*8 +: 8], exp);
    idle_all();
  endtask

  task automatic t_reset();
    for (int l = 0; l < NL; l++) rd(0, AW'(l*4), 8'h00, "R1 lock free after reset");
    @(negedge clk);
    chk("R11 idle rsp_valid", {7'b0, rsp_valid[0]}, 8'h00);
    chk("R11 idle rdata zero", rsp_rdata[7:0], 8'h00);
  endtask

  task automatic t_claim_and_foreign();
    wr(0, 8'd4, 8'h11);
    rd(0, 8'd4, 8'h11, "R2 claim free lock");
    rd(1, 8'd5, 8'h11, "R7 low address bits ignored");
    rd(1, 8'd0, 8'h00, "R7 neighbour lock untouched");
    wr(1, 8'd4, 8'h22);
    rd(1, 8'd4, 8'h11, "R4 foreign write ignored");
    wr(0, 8'd4, 8'h00);
    rd(0, 8'd4, 8'h11, "R5 zero write ignored");
    wr(0, 8'd4, 8'h11);
    rd(0, 8'd4, 8'h00, "R3 owner release");
    wr(0, 8'd4, 8'h00);
    rd(0, 8'd4, 8'h00, "R5 zero write on free lock");
    wr(1, 8'd20, 8'hFF);
    rd(0, 8'd20, 8'hFF, "R2 claim by max id");
    wr(1, 8'd20, 8'hFF);
    rd(0, 8'd20, 8'h00, "R3 release by max id");
  endtask

  task automatic t_range();
    wr(0, 8'd24, 8'h33);
    rd(0, 8'd24, 8'h00, "R6 out of range read");
    wr(1, 8'd252, 8'h34);
    rd(1, 8'd252, 8'h00, "R6 top address read");
    for (int l = 0; l < NL; l++) rd(1, AW'(l*4), 8'h00, "R6 no alias into locks");
  endtask

  task automatic t_collide();
    wr2(8'd12, 8'h41, 8'd12, 8'h52);
    rd(1, 8'd12, 8'h41, "R8 lower port wins claim");
    wr2(8'd12, 8'h52, 8'd12, 8'h41);
    rd(0, 8'd12, 8'h41, "R8 higher port release dropped");
    wr2(8'd12, 8'h00, 8'd12, 8'h41);
    rd(0, 8'd12, 8'h00, "R8 zero write does not block release");
    wr2(8'd0, 8'h0A, 8'd20, 8'h0B);
    rd(0, 8'd0, 8'h0A, "R10 parallel claim port0");
    rd(1, 8'd20, 8'h0B, "R10 parallel claim port1");
    wr2(8'd20, 8'h0B, 8'd0, 8'h0A);
    rd(0, 8'd0, 8'h00, "R10 parallel release lock0");
    rd(0, 8'd20, 8'h00, "R10 parallel release lock5");
  endtask

  task automatic t_latency();
    @(negedge clk);
    set_port(0, 1'b1, 1'b1, 8'd8, 8'h61);
    set_port(1, 1'b1, 1'b0, 8'd8, 8'h00);
    @(negedge clk);
    chk("R9 same-cycle read rsp_valid", {7'b0, rsp_valid[1]}, 8'h01);
    chk("R9 same-cycle read sees old value", rsp_rdata[15:8], 8'h00);
    chk("R11 no read on port0", rsp_rdata[7:0], 8'h00);
    idle_all();
    @(negedge clk);
    chk("R9 rsp_valid drops after one cycle", {7'b0, rsp_valid[1]}, 8'h00);
    rd(1, 8'd8, 8'h61, "R9 later read sees write");
    wr(0, 8'd8, 8'h61);
    rd(1, 8'd8, 8'h00, "R3 release after latency test");
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = '0; req_write = '0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_claim_and_foreign();
    t_range();
    t_collide();
    t_latency();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule